// File: doc/BRIEF.md
# Application Image Watchdog

This block guards a freshly loaded application image. After the image reaches user mode, a down-counter runs from a programmed timeout. The running design must keep restarting the counter through an active-low restart request. If the restarts stop because the image has hung or misbehaves, the counter reaches zero. The block then emits a one-cycle expiry pulse. Surrounding logic uses that pulse to record the watchdog as the cause of reconfiguration and to fall back to the safe factory image.

The counter runs on a slow free-running oscillator clock, nominally 10 MHz and anywhere from 5 to 10 MHz. The reload value is the 12-bit timeout setting followed by a block of zero bits, 17 by default, so one step of the setting equals 2^17 oscillator cycles. Counting is permitted only under four conditions together:
- the watchdog enable is set;
- the loaded image is an application image;
- the device is in remote update mode;
- the image has entered user mode.

Whenever any of these is missing, the counter stays loaded with its full value. The restart request comes from another clock domain and passes through a synchronizer before its falling edge is detected.

Top module: `appimg_watchdog`

## Requirements
- R1: After reset is released, `expire_o` is low. The counter is loaded before it counts: with the run conditions already true when reset is released, the pulse appears 2^PAD_W·S + 2 oscillator edges after release, where S is the setting.
- R2: The reload value is the setting S (12 bits) with PAD_W zero bits appended below it. Once the run conditions become true, `expire_o` goes high after exactly S·2^PAD_W + 1 rising edges.
- R3: Expiry is a single one-cycle pulse. The counter then holds at zero and raises no further pulse for as long as it keeps running without a restart.
- R4: While `app_image_i` is 0 (factory image loaded), no pulse is produced, however long the wait.
- R5: While `remote_mode_i` is 0 (local update mode), no pulse is produced.
- R6: While `wd_enable_i` is 0, no pulse is produced.
- R7: While `user_mode_i` is 0 (image still loading), no pulse is produced.
- R8: A falling edge on `restart_n_i` reloads the counter. It passes a synchronizer of SYNC_STAGES flops (2 by default) and one edge-detect stage. A fall driven between edges therefore yields a pulse S·2^PAD_W + 4 edges later when nothing else intervenes.
- R9: Only the falling edge restarts. Holding `restart_n_i` low does not keep reloading the counter, and a rising edge has no effect.
- R10: Removing any run condition for at least one edge reloads the counter. When the condition returns, a full S·2^PAD_W + 1 edges pass before the pulse, also after an earlier expiry.
- R11: A restart after expiry rearms the watchdog, so a second pulse follows the R8 timing.
- R12: A setting of 0 makes the watchdog expire on the first running edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc_i | input | 1 | Free-running oscillator clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| wd_setting_i | input | SET_W | Timeout setting, upper bits of the reload value |
| wd_enable_i | input | 1 | Watchdog enable |
| restart_n_i | input | 1 | Active-low restart request, asynchronous to clk_osc_i |
| user_mode_i | input | 1 | High once the loaded image has entered user mode |
| app_image_i | input | 1 | 1 = application image loaded, 0 = factory image |
| remote_mode_i | input | 1 | 1 = remote update mode, 0 = local update mode |
| expire_o | output | 1 | One-cycle timeout pulse |

## Verification
The bench shrinks the padding to 3 bits so that timeouts stay short. It measures the cycle count to expiry for a set of settings that includes 0, 1, small and large values, which pins down the reload arithmetic and the off-by-one at zero. Each run condition is withheld in turn over a window several times the timeout, then released, to show both that the condition blocks expiry and that it reloaded the counter. Restart patterns are tried separately to tell edge sensitivity apart from level sensitivity and to show that a restart rearms after expiry:
- a single fall;
- a fall held low;
- a rise;
- a fall after expiry.

// File: rtl/appwd_pkg.sv
package appwd_pkg;
  localparam int unsigned SET_W_DEF       = 12;
  localparam int unsigned PAD_W_DEF       = 17;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  // counter phase, exposed for readability of the counter logic
  typedef enum logic [1:0] {
    PH_LOAD  = 2'd0,
    PH_COUNT = 2'd1,
    PH_FIRE  = 2'd2,
    PH_HOLD  = 2'd3
  } wd_phase_e;
endpackage

// File: rtl/appwd_restart_sync.sv
module appwd_restart_sync #(
  parameter int unsigned STAGES = appwd_pkg::SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic async_n_i,
  output logic fall_o
);
  localparam int unsigned LAST = STAGES;

  logic [LAST:0] sh_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("appwd_restart_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sh_q <= '1;
    else          sh_q <= {sh_q[LAST-1:0], async_n_i};
  end

  // previous synchronized value high, current low
  assign fall_o = sh_q[LAST] & ~sh_q[LAST-1];

  p_fall_single_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    fall_o |=> !fall_o);
endmodule

// File: rtl/appwd_run_gate.sv
module appwd_run_gate (
  input  logic enable_i,
  input  logic app_image_i,
  input  logic remote_mode_i,
  input  logic user_mode_i,
  output logic run_o
);
  logic [3:0] cond_w;

  assign cond_w = {enable_i, app_image_i, remote_mode_i, user_mode_i};
  assign run_o  = &cond_w;
endmodule

// File: rtl/appwd_counter.sv
module appwd_counter #(
  parameter int unsigned SET_W = appwd_pkg::SET_W_DEF,
  parameter int unsigned PAD_W = appwd_pkg::PAD_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [SET_W-1:0] setting_i,
  output logic             expire_o
);
  import appwd_pkg::*;
  localparam int unsigned CNT_W = SET_W + PAD_W;

  function automatic logic [CNT_W-1:0] reload_of(input logic [SET_W-1:0] s);
    return {s, {PAD_W{1'b0}}};
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             fired_q;
  logic             loaded_q;
  logic [CNT_W-1:0] reload_w;
  wd_phase_e        phase_w;

  assign reload_w = reload_of(setting_i);

  always_comb begin
    if (!run_i || restart_i || !loaded_q) phase_w = PH_LOAD;
    else if (cnt_q != '0)                 phase_w = PH_COUNT;
    else if (!fired_q)                    phase_w = PH_FIRE;
    else                                  phase_w = PH_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q    <= '0;
      fired_q  <= 1'b0;
      loaded_q <= 1'b0;
      expire_o <= 1'b0;
    end else begin
      unique case (phase_w)
        PH_LOAD: begin
          cnt_q    <= reload_w;
          fired_q  <= 1'b0;
          loaded_q <= 1'b1;
          expire_o <= 1'b0;
        end
        PH_COUNT: begin
          cnt_q    <= cnt_q - 1'b1;
          expire_o <= 1'b0;
        end
        PH_FIRE: begin
          fired_q  <= 1'b1;
          expire_o <= 1'b1;
        end
        default: begin
          expire_o <= 1'b0;
        end
      endcase
    end
  end

  p_single_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    expire_o |=> !expire_o);
  p_hold_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (run_i && !restart_i && loaded_q && cnt_q == '0) |=> (cnt_q == '0));
  p_count_down_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (run_i && !restart_i && loaded_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_reload_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (run_i && restart_i) |=> (cnt_q == $past(reload_w) && !expire_o));
  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !run_i |=> !expire_o);
endmodule

// File: rtl/appimg_watchdog.sv
module appimg_watchdog #(
  parameter int unsigned SET_W       = appwd_pkg::SET_W_DEF,
  parameter int unsigned PAD_W       = appwd_pkg::PAD_W_DEF,
  parameter int unsigned SYNC_STAGES = appwd_pkg::SYNC_STAGES_DEF
) (
  input  logic             clk_osc_i,
  input  logic             rst_n_i,
  input  logic [SET_W-1:0] wd_setting_i,
  input  logic             wd_enable_i,
  input  logic             restart_n_i,
  input  logic             user_mode_i,
  input  logic             app_image_i,
  input  logic             remote_mode_i,
  output logic             expire_o
);
  logic run_w;
  logic restart_fall_w;

  appwd_restart_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_osc_i),
    .rst_n_i  (rst_n_i),
    .async_n_i(restart_n_i),
    .fall_o   (restart_fall_w)
  );

  appwd_run_gate u_gate (
    .enable_i     (wd_enable_i),
    .app_image_i  (app_image_i),
    .remote_mode_i(remote_mode_i),
    .user_mode_i  (user_mode_i),
    .run_o        (run_w)
  );

  appwd_counter #(.SET_W(SET_W), .PAD_W(PAD_W)) u_cnt (
    .clk_i    (clk_osc_i),
    .rst_n_i  (rst_n_i),
    .run_i    (run_w),
    .restart_i(restart_fall_w),
    .setting_i(wd_setting_i),
    .expire_o (expire_o)
  );

  p_factory_quiet_r4: assert property (@(posedge clk_osc_i) disable iff (!rst_n_i)
    !app_image_i |=> !expire_o);
  p_local_quiet_r5: assert property (@(posedge clk_osc_i) disable iff (!rst_n_i)
    !remote_mode_i |=> !expire_o);
  p_loading_quiet_r7: assert property (@(posedge clk_osc_i) disable iff (!rst_n_i)
    !user_mode_i |=> !expire_o);
  p_enable_quiet_r6: assert property (@(posedge clk_osc_i) disable iff (!rst_n_i)
    !wd_enable_i |=> !expire_o);
endmodule

// File: tb/appimg_watchdog_tb.sv
module appimg_watchdog_tb;
  localparam int SET_W = 12;
  localparam int PAD_W = 3;
  localparam int STEP  = 8;  // 2**PAD_W, restated for expected values

  localparam int VEC_N = 6;
  localparam int VSET [VEC_N] = '{1, 3, 0, 10, 255, 2};
  localparam int VEXP [VEC_N] = '{9, 25, 1, 81, 2041, 17};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SET_W-1:0] setting = '0;
  logic en = 1'b0, restart_n = 1'b1, umode = 1'b0, app = 1'b0, remote = 1'b0;
  logic expire;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  appimg_watchdog #(.SET_W(SET_W), .PAD_W(PAD_W)) u_dut (
    .clk_osc_i(clk), .rst_n_i(rst_n), .wd_setting_i(setting),
    .wd_enable_i(en), .restart_n_i(restart_n), .user_mode_i(umode),
    .app_image_i(app), .remote_mode_i(remote), .expire_o(expire)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic gates(input logic e, input logic a, input logic r, input logic u);
    en = e; app = a; remote = r; umode = u;
  endtask

  // edges until expire_o is seen high; -1 if not within limit
  task automatic edges_to_pulse(input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); @(negedge clk);
      if (expire) begin n = i; break; end
    end
  endtask

  task automatic count_pulses(input int len, output int p);
    p = 0;
    for (int i = 0; i < len; i++) begin
      @(posedge clk); @(negedge clk);
      if (expire) p++;
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, p;
    idle(0);
    @(negedge clk); idle(4);
    rst_n = 1'b1;
    idle(1);
    chk("R1 reset output", int'(expire), 0);

    // table walk: settings vs edges-to-expiry
    for (int v = 0; v < VEC_N; v++) begin
      gates(0, 1, 1, 1);
      setting = SET_W'(VSET[v]);
      idle(1);
      gates(1, 1, 1, 1);
      edges_to_pulse(3000, n);
      chk("R2 expiry time", n, VEXP[v]);
      count_pulses(30, p);
      chk("R3 single pulse then hold", p, 0);
    end

    // R12 setting zero
    gates(0, 1, 1, 1); setting = '0; idle(1);
    gates(1, 1, 1, 1);
    edges_to_pulse(10, n);
    chk("R12 zero setting", n, 1);

    // each gate withheld, then released (reload check R10)
    setting = SET_W'(2);
    gates(1, 0, 1, 1); count_pulses(60, p); chk("R4 factory image blocks", p, 0);
    gates(1, 1, 1, 1); edges_to_pulse(100, n); chk("R10 reload after factory gate", n, 2*STEP+1);
    gates(1, 1, 0, 1); count_pulses(60, p); chk("R5 local mode blocks", p, 0);
    gates(1, 1, 1, 1); edges_to_pulse(100, n); chk("R10 reload after local gate", n, 2*STEP+1);
    gates(0, 1, 1, 1); count_pulses(60, p); chk("R6 disabled blocks", p, 0);
    gates(1, 1, 1, 1); edges_to_pulse(100, n); chk("R10 reload after enable gate", n, 2*STEP+1);
    gates(1, 1, 1, 0); count_pulses(60, p); chk("R7 loading blocks", p, 0);
    gates(1, 1, 1, 1); edges_to_pulse(100, n); chk("R10 reload after user-mode gate", n, 2*STEP+1);

    // R10 mid-count drop
    gates(0, 1, 1, 1); idle(1);
    gates(1, 1, 1, 1); idle(10);
    gates(0, 1, 1, 1); idle(1);
    gates(1, 1, 1, 1);
    edges_to_pulse(100, n);
    chk("R10 mid-count reload", n, 2*STEP+1);

    // R8 restart fall mid-count
    gates(0, 1, 1, 1); idle(1);
    gates(1, 1, 1, 1); idle(5);
    restart_n = 1'b0;
    edges_to_pulse(100, n);
    chk("R8 restart timing", n, 2*STEP+4);

    // R9 level low and rising edge do nothing
    count_pulses(60, p);
    chk("R9 held low no reload", p, 0);
    restart_n = 1'b1;
    count_pulses(40, p);
    chk("R9 rising edge no effect", p, 0);

    // R11 rearm after expiry
    restart_n = 1'b0;
    edges_to_pulse(100, n);
    chk("R11 rearm after expiry", n, 2*STEP+4);
    restart_n = 1'b1; idle(4);

    // R1 reset while running, gates stay true
    idle(5);
    rst_n = 1'b0;
    idle(1);
    chk("R1 output low in reset", int'(expire), 0);
    rst_n = 1'b1;
    edges_to_pulse(100, n);
    chk("R1 load before count", n, 2*STEP+2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule